// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block chooses the issue slot for a multithreaded barrel processor with up to eight hardware threads. In each clock it grants issue to at most one thread. It walks through the eligible threads in ascending ID order and wraps back to the lowest ID at the end of each round. A round always lasts at least four clocks. When fewer than four threads are eligible, the round is filled out with bubble cycles, so no thread ever issues more often than once every four clocks.

A thread can ask to sleep until an event arrives. A sleeping thread drops out of the rotation and uses no slots. When its event arrives it rejoins at its ID position. A sleeping thread with its fast-mode flag set keeps its slot. Each of its grants is marked as a poll slot, so the thread can see its event on the cycle it arrives without waiting to be scheduled again. All per-thread inputs are registered, so a change at the inputs takes effect at the outputs from the next clock.

Top module: `barrel_issue_sched`

## Requirements
- R1: After reset no thread is enabled and the rotation pointer is 0. `issue_vld`, `pad_slot` and `poll_slot` are all low. The first grant after threads are enabled goes to the lowest enabled ID.
- R2: In any clock, at most one of `issue_vld` and `pad_slot` is high. A grant names a thread whose enable was high at the previous clock edge.
- R3: Grants follow ascending thread ID and wrap from the highest eligible ID back to the lowest. A thread that becomes eligible with an ID below the rotation pointer is first served in the next round.
- R4: No thread is granted twice within any four consecutive clocks, including when the set of eligible threads shrinks in the middle of a round.
- R5: With one to three eligible threads, each round holds exactly four clocks, with bubble cycles after the grants. Each thread is granted once every four clocks.
- R6: With n eligible threads and n of at least four, the grant sequence repeats every n clocks and grants each thread once per period.
- R7: A one-clock `sleep_req` pulse on an enabled thread puts it to sleep from the next clock. A sleeping thread without fast mode is never granted.
- R8: An `wake_evt` pulse wakes a sleeping thread from the next clock, and the thread rejoins the rotation. A `wake_evt` pulse for a thread that is not sleeping changes nothing.
- R9: A sleeping thread with `fast_mode` set stays in the rotation. `poll_slot` is high exactly on its grants. `poll_slot` is never high without `issue_vld`.
- R10: Clearing a thread's enable removes it from the rotation from the next clock and clears any sleep state it held. When it is re-enabled without a new `sleep_req`, it issues normally.
- R11: `pad_slot` is high in a clock with no grant while at least one thread is eligible. It stays low when no thread is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_en | input | NUM_THREADS | Per-thread enable |
| sleep_req | input | NUM_THREADS | Per-thread request to sleep until an event (pulse) |
| wake_evt | input | NUM_THREADS | Per-thread event arrival (pulse) |
| fast_mode | input | NUM_THREADS | Per-thread flag to keep the slot while sleeping |
| issue_vld | output | 1 | A thread is granted issue this clock |
| issue_tid | output | TID_W | ID of the granted thread |
| pad_slot | output | 1 | Bubble cycle: no issue although a thread is eligible |
| poll_slot | output | 1 | The granted thread is sleeping in fast mode |

## Verification
On every cycle the assertions check four things: grant and bubble never occur together, a grant only goes to a thread that was enabled and is not sleeping without fast mode, the same thread is never granted within a four-clock window, and poll and bubble flags agree with the grant and eligibility state. Some behaviour needs a known history, and only the directed scenarios can show it. This covers the exact ascending order, the periods of four and n, the bubble padding, the delayed entry of a thread behind the pointer, rejoining after an event, and the clearing of sleep state when enable drops.

// File: rtl/bts_pkg.sv
package bts_pkg;

  localparam int VEC_W = 32;

  // index of the lowest set bit at or above 'start'; VEC_W when none
  function automatic int lowest_from(logic [VEC_W-1:0] v, int start);
    int idx;
    idx = VEC_W;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (v[i] && i >= start) idx = i;
    end
    return idx;
  endfunction

  // mask with bits at and above 'start' set
  function automatic logic [VEC_W-1:0] at_or_above(int start);
    logic [VEC_W-1:0] m;
    for (int i = 0; i < VEC_W; i++) m[i] = (i >= start);
    return m;
  endfunction

  // saturating increment of a small counter
  function automatic int sat_inc(int v, int limit);
    return (v >= limit) ? limit : v + 1;
  endfunction

endpackage

// File: rtl/bts_thread_state.sv
module bts_thread_state #(
  parameter int NUM_THREADS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thr_en,
  input  logic [NUM_THREADS-1:0] sleep_req,
  input  logic [NUM_THREADS-1:0] wake_evt,
  input  logic [NUM_THREADS-1:0] fast_mode,
  output logic [NUM_THREADS-1:0] en_q,
  output logic [NUM_THREADS-1:0] sleep_q,
  output logic [NUM_THREADS-1:0] fast_q,
  output logic [NUM_THREADS-1:0] elig
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic sleep_d;
    // an event wins over a simultaneous request; disabling clears sleep
    assign sleep_d = thr_en[t] & ~wake_evt[t] & (sleep_q[t] | sleep_req[t]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[t]    <= 1'b0;
        sleep_q[t] <= 1'b0;
        fast_q[t]  <= 1'b0;
      end else begin
        en_q[t]    <= thr_en[t];
        sleep_q[t] <= sleep_d;
        fast_q[t]  <= fast_mode[t];
      end
    end

    assign elig[t] = en_q[t] & (~sleep_q[t] | fast_q[t]);
  end

endmodule

// File: rtl/bts_cooldown.sv
module bts_cooldown #(
  parameter int NUM_THREADS = 8,
  parameter int MIN_ROUND   = 4,
  parameter int TID_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_vld,
  input  logic [TID_W-1:0]       issue_tid,
  output logic [NUM_THREADS-1:0] busy
);

  localparam int CW = (MIN_ROUND > 2) ? $clog2(MIN_ROUND) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(MIN_ROUND - 1);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cool
    logic [CW-1:0] cnt;
    logic          hit;
    assign hit = issue_vld && (int'(issue_tid) == t);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (hit)         cnt <= RELOAD;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy[t] = (cnt != '0);
  end

endmodule

// File: rtl/bts_rotation.sv
module bts_rotation
  import bts_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int MIN_ROUND   = 4,
  parameter int TID_W       = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] elig,
  input  logic [NUM_THREADS-1:0] busy,
  output logic                   issue_vld,
  output logic [TID_W-1:0]       issue_tid,
  output logic                   pad_slot,
  output logic                   round_wrap
);

  localparam int PW = $clog2(NUM_THREADS + 1);
  localparam int SW = $clog2(MIN_ROUND + 1);

  logic [PW-1:0]    ptr_q;
  logic [SW-1:0]    slot_q;
  logic [VEC_W-1:0] elig_w;
  logic [VEC_W-1:0] ahead;
  logic             any_elig, has_ahead, round_full, head_vld;
  int               head_idx;

  always_comb begin
    elig_w     = VEC_W'(elig);
    ahead      = elig_w & at_or_above(int'(ptr_q));
    any_elig   = |elig;
    has_ahead  = |ahead;
    round_full = int'(slot_q) >= MIN_ROUND;
    round_wrap = any_elig && !has_ahead && round_full;
    head_vld   = has_ahead || round_wrap;
    head_idx   = has_ahead ? lowest_from(ahead, 0) : lowest_from(elig_w, 0);
    if (head_idx >= NUM_THREADS) head_idx = 0;
    issue_vld  = head_vld && !busy[head_idx];
    issue_tid  = TID_W'(head_idx);
    pad_slot   = any_elig && !issue_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      slot_q <= '0;
    end else if (any_elig) begin
      if (issue_vld) begin
        ptr_q  <= PW'(head_idx + 1);
        slot_q <= round_wrap ? SW'(1) : SW'(sat_inc(int'(slot_q), MIN_ROUND));
      end else if (round_wrap) begin
        ptr_q  <= '0;
        slot_q <= SW'(1);
      end else begin
        slot_q <= SW'(sat_inc(int'(slot_q), MIN_ROUND));
      end
    end
  end

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched #(
  parameter int NUM_THREADS = 8,
  parameter int MIN_ROUND   = 4,
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thr_en,
  input  logic [NUM_THREADS-1:0] sleep_req,
  input  logic [NUM_THREADS-1:0] wake_evt,
  input  logic [NUM_THREADS-1:0] fast_mode,
  output logic                   issue_vld,
  output logic [TID_W-1:0]       issue_tid,
  output logic                   pad_slot,
  output logic                   poll_slot
);

  logic [NUM_THREADS-1:0] en_vec, sleep_vec, fast_vec, elig_vec, busy_vec;
  logic                   round_wrap;

  bts_thread_state #(.NUM_THREADS(NUM_THREADS)) u_state (
    .clk(clk), .rst_n(rst_n),
    .thr_en(thr_en), .sleep_req(sleep_req), .wake_evt(wake_evt), .fast_mode(fast_mode),
    .en_q(en_vec), .sleep_q(sleep_vec), .fast_q(fast_vec), .elig(elig_vec)
  );

  bts_cooldown #(.NUM_THREADS(NUM_THREADS), .MIN_ROUND(MIN_ROUND), .TID_W(TID_W)) u_cool (
    .clk(clk), .rst_n(rst_n),
    .issue_vld(issue_vld), .issue_tid(issue_tid), .busy(busy_vec)
  );

  bts_rotation #(.NUM_THREADS(NUM_THREADS), .MIN_ROUND(MIN_ROUND), .TID_W(TID_W)) u_rot (
    .clk(clk), .rst_n(rst_n),
    .elig(elig_vec), .busy(busy_vec),
    .issue_vld(issue_vld), .issue_tid(issue_tid), .pad_slot(pad_slot),
    .round_wrap(round_wrap)
  );

  assign poll_slot = issue_vld && sleep_vec[issue_tid];

endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int NUM_THREADS = 8,
  parameter int TID_W       = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_THREADS-1:0] thr_en,
  input logic                   issue_vld,
  input logic [TID_W-1:0]       issue_tid,
  input logic                   pad_slot,
  input logic                   poll_slot,
  input logic [NUM_THREADS-1:0] elig_vec,
  input logic [NUM_THREADS-1:0] sleep_vec,
  input logic [NUM_THREADS-1:0] fast_vec
);

  logic [NUM_THREADS-1:0] tid_oh;
  assign tid_oh = NUM_THREADS'(1) << issue_tid;

  // R2
  grant_pad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_vld && pad_slot));

  // R2
  grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> (($past(thr_en) & tid_oh) != '0));

  // R7
  no_sleeper_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> ((sleep_vec & ~fast_vec & tid_oh) == '0));

  // R4
  gap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && $past(issue_vld)) |-> (issue_tid != $past(issue_tid)));

  // R4
  gap_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && $past(issue_vld, 2)) |-> (issue_tid != $past(issue_tid, 2)));

  // R4
  gap_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && $past(issue_vld, 3)) |-> (issue_tid != $past(issue_tid, 3)));

  // R9
  poll_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_slot |-> issue_vld);

  // R11
  pad_needs_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_slot |-> (elig_vec != '0));

  // R11
  elig_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec != '0) |-> (issue_vld || pad_slot));

endmodule

bind barrel_issue_sched bts_checker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_en(thr_en),
  .issue_vld(issue_vld), .issue_tid(issue_tid), .pad_slot(pad_slot), .poll_slot(poll_slot),
  .elig_vec(elig_vec), .sleep_vec(sleep_vec), .fast_vec(fast_vec)
);

// File: tb/tb_barrel_issue_sched.sv
module tb_barrel_issue_sched;

  localparam int NT = 8;
  localparam int B  = -1;  // bubble
  localparam int I  = -2;  // idle

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] thr_en = '0, sleep_req = '0, wake_evt = '0, fast_mode = '0;
  logic          issue_vld, pad_slot, poll_slot;
  logic [2:0]    issue_tid;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  barrel_issue_sched dut (
    .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .sleep_req(sleep_req),
    .wake_evt(wake_evt), .fast_mode(fast_mode), .issue_vld(issue_vld),
    .issue_tid(issue_tid), .pad_slot(pad_slot), .poll_slot(poll_slot)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<20000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic int observe();
    if (issue_vld && pad_slot) return -9;
    if (issue_vld) return int'(issue_tid);
    if (pad_slot)  return B;
    return I;
  endfunction

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one clock edge; pulse inputs last exactly one edge
  task automatic step();
    @(posedge clk); #1;
    sleep_req = '0;
    wake_evt  = '0;
  endtask

  task automatic expect_seq(string req, int exp[$]);
    foreach (exp[k]) begin
      step();
      check(req, observe(), exp[k]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    thr_en = '0; sleep_req = '0; wake_evt = '0; fast_mode = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // R1 R11: quiet after reset, first grant to lowest ID
  task automatic t_reset();
    do_reset();
    check("R1 reset vld", int'(issue_vld), 0);
    check("R1 reset pad", int'(pad_slot), 0);
    check("R1 reset poll", int'(poll_slot), 0);
    step();
    check("R11 idle no pad", observe(), I);
    thr_en = 8'h0C;
    expect_seq("R1 first grant", '{2});
  endtask

  // R6: all eight threads, period eight
  task automatic t_all8();
    do_reset();
    thr_en = 8'hFF;
    expect_seq("R6 eight", '{0,1,2,3,4,5,6,7,0,1,2,3,4,5,6,7});
  endtask

  // R6 R3: five sparse threads
  task automatic t_five();
    do_reset();
    thr_en = 8'hAD;
    expect_seq("R6 five", '{0,2,3,5,7,0,2,3,5,7});
  endtask

  // R5: two threads padded to four
  task automatic t_two();
    do_reset();
    thr_en = 8'h06;
    expect_seq("R5 pad", '{1,2,B,B,1,2,B,B,1,2,B,B});
  endtask

  // R7 R8: sleep, wake, stray event, all asleep
  task automatic t_sleep();
    do_reset();
    thr_en = 8'h0F; sleep_req = 8'h04;
    expect_seq("R7 sleeper skipped", '{0,1,3,B,0,1,3,B});
    wake_evt = 8'h04;
    expect_seq("R8 rejoin", '{0,1,2,3,0,1,2,3});
    wake_evt = 8'h01;
    expect_seq("R8 stray event", '{0,1,2,3});
    do_reset();
    thr_en = 8'h01; sleep_req = 8'h01;
    expect_seq("R11 all asleep idle", '{I,I,I});
  endtask

  // R9: fast mode keeps slot, poll flag on its grants
  task automatic t_fast();
    do_reset();
    thr_en = 8'h0F; sleep_req = 8'h04; fast_mode = 8'h04;
    for (int k = 0; k < 8; k++) begin
      step();
      check("R9 fast order", observe(), k % 4);
      check("R9 poll flag", int'(poll_slot), (k % 4 == 2) ? 1 : 0);
    end
  endtask

  // R10: disable drops next clock and clears sleep
  task automatic t_disable();
    do_reset();
    thr_en = 8'h0F;
    expect_seq("R10 start", '{0});
    thr_en = 8'h0D;
    expect_seq("R10 drop", '{2,3,B,0,2,3,B});
    do_reset();
    thr_en = 8'h0F; sleep_req = 8'h02;
    expect_seq("R10 asleep", '{0,2,3,B});
    thr_en = 8'h0D;
    expect_seq("R10 off", '{0});
    thr_en = 8'h0F;
    expect_seq("R10 sleep cleared", '{1,2,3,0});
  endtask

  // R4: shrinking set mid-round keeps four-clock spacing
  task automatic t_cool();
    do_reset();
    thr_en = 8'h0F;
    expect_seq("R4 start", '{0,1,2,3});
    thr_en = 8'h08;
    expect_seq("R4 spacing", '{B,B,B,3,B,B,B,3});
  endtask

  // R3: thread behind the pointer waits for next round
  task automatic t_behind();
    do_reset();
    thr_en = 8'h04;
    expect_seq("R3 single", '{2});
    thr_en = 8'h05;
    expect_seq("R3 behind ptr", '{B,B,B,0,2,B,B});
  endtask

  initial begin
    t_reset();
    t_all8();
    t_five();
    t_two();
    t_sleep();
    t_fast();
    t_disable();
    t_cool();
    t_behind();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule